// File: doc/BRIEF.md
# Handshake Parallel Port Controller

This block drives two general-purpose parallel ports of configurable width (A and B) and a 6-pin control port C, all under a 6-bit command value that the host writes through a decoded strobe. Ports A and B each take a direction from the command. Port C runs in one of four modes. In two of those modes some of its pins become handshake lines for A, or for A and B: an incoming strobe from the peripheral, a buffer flag driven out, and an interrupt request driven out.

Each port has a small handshake state machine. It follows the synchronized strobe through two states. `HS_IDLE` means the strobe is high. `HS_ARMED` means the strobe is low. The transitions are:
- *strobe-fall* (`HS_IDLE`→`HS_ARMED`) on a low strobe;
- *strobe-rise* (`HS_ARMED`→`HS_IDLE`) on a high strobe;
- *disarm* (any→`HS_IDLE`) whenever handshake is not active for that port.

On strobe-fall the buffer flag sets, and an input port also captures its pins. On strobe-rise the interrupt request sets if it is enabled. A host read (input port) or host write (output port) clears both flags. The flags and the two enable bits are packed into a 6-bit status word. Address decode and any timer are outside the block.

Top module: `hsport_ctrl`

## Requirements
- R1: After reset the command value is zero: `pa_oe`, `pb_oe` and `pc_oe` are all zero, and `status` is zero.
- R2: Command bit 0 sets the port A direction and bit 1 sets the port B direction (1 = output, every bit of `pa_oe`/`pb_oe` high; 0 = input). An input port that is not in handshake returns its live pins on its read data.
- R3: `wr_a`/`wr_b` load `wr_data` into the port output latch. The latch drives `pa_out`/`pb_out`, and an output port's read data returns the latch.
- R4: Command bits 3:2 pick the port C mode.
  - 00: all six pins are inputs (`pc_oe`=000000).
  - 11: all six pins are outputs (`pc_oe`=111111), driven from the port C latch loaded by `wr_c` from `wr_data[5:0]`.
  - 01: A handshake. Pin 0 is the A strobe input, pin 1 drives the A buffer flag, pin 2 drives the A request, and pins 5..3 are latch outputs (`pc_oe`=111110).
  - 10: A and B handshake. Pins 2..0 are used as in mode 01, and pins 5..3 serve B in the same order (`pc_oe`=110110).
- R5: `status` bit 0 is the A request, bit 1 the A buffer flag, bit 2 the A interrupt enable (command bit 4), bit 3 the B request, bit 4 the B buffer flag, and bit 5 the B interrupt enable (command bit 5).
- R6: For an input port in handshake, a low strobe captures the port pins and sets the buffer flag (full). The port's read data then returns the captured value even if the pins change.
- R7: A rising strobe sets the port's request only if its interrupt-enable bit is 1. With the bit at 0, the request stays 0.
- R8: For an input port in handshake, a host read (`rd_a`/`rd_b`) clears both the buffer flag and the request.
- R9: For an output port in handshake, a host write clears the buffer flag (here meaning empty) and the request. A low strobe sets the flag, and the strobe's rise sets the request if enabled.
- R10: Strobes pass through a two-flop synchronizer. A flag set by a strobe edge appears after the third rising clock edge that follows the pin change, and not after the second.
- R11: A port not in handshake mode ignores its strobe pin: its buffer flag and request stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_wr | input | 1 | Load the command value |
| cmd_in | input | 6 | Command value |
| wr_a | input | 1 | Host write to port A |
| wr_b | input | 1 | Host write to port B |
| wr_c | input | 1 | Host write to the port C latch |
| wr_data | input | PW | Host write data |
| rd_a | input | 1 | Host read of port A |
| rd_b | input | 1 | Host read of port B |
| pa_in | input | PW | Port A pins in |
| pa_out | output | PW | Port A pins out |
| pa_oe | output | PW | Port A output enables |
| pb_in | input | PW | Port B pins in |
| pb_out | output | PW | Port B pins out |
| pb_oe | output | PW | Port B output enables |
| pc_in | input | PCW | Port C pins in |
| pc_out | output | PCW | Port C pins out |
| pc_oe | output | PCW | Port C output enables |
| pa_rdata | output | PW | Port A read data |
| pb_rdata | output | PW | Port B read data |
| pc_rdata | output | PCW | Port C read data |
| status | output | 6 | Packed flags and enables |

## Verification
The bench targets strobe timing at exact cycles.
- It checks that the buffer flag is still clear two edges after a strobe falls and set on the third. A missing or extra synchronizer stage would fail one of these two samples.
- It changes the pins after capture. A design that passed live pins through during handshake would return the wrong value.
- It pulses a strobe with the enable clear, and again with port C in all-input mode. A design that ignored the enable, or did not gate handshake by mode, would raise a request or flag.
- It drives an output-direction handshake on port B. A design that cleared on the wrong host access (read instead of write) would keep the flags set.

// File: rtl/hsport_pkg.sv
package hsport_pkg;
    typedef enum logic [1:0] {
        PCM_ALLIN  = 2'b00,
        PCM_HSA    = 2'b01,
        PCM_HSAB   = 2'b10,
        PCM_ALLOUT = 2'b11
    } pc_mode_e;

    typedef enum logic {
        HS_IDLE  = 1'b0,
        HS_ARMED = 1'b1
    } hs_state_e;
endpackage

// File: rtl/hsport_sync.sv
module hsport_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sr;

    // Reset to the strobe's inactive (high) level.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr <= '1;
        else        sr <= {sr[STAGES-2:0], d};
    end

    assign q = sr[STAGES-1];
endmodule

// File: rtl/hsport_hs.sv
module hsport_hs
    import hsport_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         active,
    input  logic         dir_out,
    input  logic         int_en,
    input  logic         stb_s,
    input  logic         cpu_rd,
    input  logic         cpu_wr,
    input  logic [W-1:0] pins,
    output logic         bf,
    output logic         intr,
    output logic [W-1:0] cap
);
    hs_state_e state_q, state_d;
    logic      stb_fall, stb_rise, cpu_clr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= HS_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (!active) begin
            state_d = HS_IDLE;                 // disarm
        end else begin
            unique case (state_q)
                HS_IDLE:  if (!stb_s) state_d = HS_ARMED;  // strobe-fall
                HS_ARMED: if (stb_s)  state_d = HS_IDLE;   // strobe-rise
            endcase
        end
    end

    assign stb_fall = active && (state_q == HS_IDLE)  && !stb_s;
    assign stb_rise = active && (state_q == HS_ARMED) &&  stb_s;
    assign cpu_clr  = dir_out ? cpu_wr : cpu_rd;

    // Flags: a strobe event in the same cycle as a host access wins.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bf   <= 1'b0;
            intr <= 1'b0;
            cap  <= '0;
        end else if (!active) begin
            bf   <= 1'b0;
            intr <= 1'b0;
        end else begin
            if (stb_fall)     bf <= 1'b1;
            else if (cpu_clr) bf <= 1'b0;
            if (stb_rise && int_en) intr <= 1'b1;
            else if (cpu_clr)       intr <= 1'b0;
            if (stb_fall && !dir_out) cap <= pins;
        end
    end
endmodule

// File: rtl/hsport_ctrl.sv
module hsport_ctrl
    import hsport_pkg::*;
#(
    parameter int PW  = 8,
    parameter int PCW = 6
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cmd_wr,
    input  logic [5:0]     cmd_in,
    input  logic           wr_a,
    input  logic           wr_b,
    input  logic           wr_c,
    input  logic [PW-1:0]  wr_data,
    input  logic           rd_a,
    input  logic           rd_b,
    input  logic [PW-1:0]  pa_in,
    output logic [PW-1:0]  pa_out,
    output logic [PW-1:0]  pa_oe,
    input  logic [PW-1:0]  pb_in,
    output logic [PW-1:0]  pb_out,
    output logic [PW-1:0]  pb_oe,
    input  logic [PCW-1:0] pc_in,
    output logic [PCW-1:0] pc_out,
    output logic [PCW-1:0] pc_oe,
    output logic [PW-1:0]  pa_rdata,
    output logic [PW-1:0]  pb_rdata,
    output logic [PCW-1:0] pc_rdata,
    output logic [5:0]     status
);
    localparam int NPORT = 2;
    localparam int HSPIN = PCW / NPORT;   // pins per handshake group

    logic [5:0]     cmd_q;
    logic [PW-1:0]  pa_q, pb_q;
    logic [PCW-1:0] pc_q;
    pc_mode_e       mode;

    logic [NPORT-1:0] act, dir, ie, rdv, wrv, stb_s, bf, intr;
    logic [PW-1:0]    pins [NPORT];
    logic [PW-1:0]    cap  [NPORT];
    logic             stb_a_s, hs_a_act;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q <= '0;
            pa_q  <= '0;
            pb_q  <= '0;
            pc_q  <= '0;
        end else begin
            if (cmd_wr) cmd_q <= cmd_in;
            if (wr_a)   pa_q  <= wr_data;
            if (wr_b)   pb_q  <= wr_data;
            if (wr_c)   pc_q  <= wr_data[PCW-1:0];
        end
    end

    assign mode   = pc_mode_e'(cmd_q[3:2]);
    assign act[0] = (mode == PCM_HSA) || (mode == PCM_HSAB);
    assign act[1] = (mode == PCM_HSAB);
    assign dir    = cmd_q[1:0];
    assign ie     = cmd_q[5:4];
    assign rdv    = {rd_b, rd_a};
    assign wrv    = {wr_b, wr_a};
    assign pins[0] = pa_in;
    assign pins[1] = pb_in;

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        hsport_sync #(.STAGES(2)) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .d     (pc_in[p*HSPIN]),
            .q     (stb_s[p])
        );
        hsport_hs #(.W(PW)) u_hs (
            .clk     (clk),
            .rst_n   (rst_n),
            .active  (act[p]),
            .dir_out (dir[p]),
            .int_en  (ie[p]),
            .stb_s   (stb_s[p]),
            .cpu_rd  (rdv[p]),
            .cpu_wr  (wrv[p]),
            .pins    (pins[p]),
            .bf      (bf[p]),
            .intr    (intr[p]),
            .cap     (cap[p])
        );
    end

    assign stb_a_s  = stb_s[0];
    assign hs_a_act = act[0];

    always_comb begin
        unique case (mode)
            PCM_ALLIN: begin
                pc_oe  = '0;
                pc_out = '0;
            end
            PCM_ALLOUT: begin
                pc_oe  = '1;
                pc_out = pc_q;
            end
            PCM_HSA: begin
                pc_oe  = 6'b111110;
                pc_out = {pc_q[5:3], intr[0], bf[0], 1'b0};
            end
            PCM_HSAB: begin
                pc_oe  = 6'b110110;
                pc_out = {intr[1], bf[1], 1'b0, intr[0], bf[0], 1'b0};
            end
        endcase
    end

    assign pa_oe    = {PW{dir[0]}};
    assign pb_oe    = {PW{dir[1]}};
    assign pa_out   = pa_q;
    assign pb_out   = pb_q;
    assign pa_rdata = dir[0] ? pa_q : (act[0] ? cap[0] : pa_in);
    assign pb_rdata = dir[1] ? pb_q : (act[1] ? cap[1] : pb_in);
    assign pc_rdata = (pc_oe & pc_out) | (~pc_oe & pc_in);
    assign status   = {ie[1], bf[1], intr[1], ie[0], bf[0], intr[0]};
endmodule

// File: rtl/hsport_ctrl_chk.sv
module hsport_ctrl_chk #(
    parameter int PW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cmd_wr,
    input logic [5:0]    cmd_in,
    input logic          wr_a,
    input logic [PW-1:0] wr_data,
    input logic [PW-1:0] pa_oe,
    input logic [PW-1:0] pa_out,
    input logic [5:0]    status,
    input logic          stb_a_s,
    input logic          hs_a_act
);
    // R2: direction follows the written command bit
    p_dir_a_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr |=> pa_oe == {PW{$past(cmd_in[0])}});

    // R3: port A latch takes the written data
    p_latch_a_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_a |=> pa_out == $past(wr_data));

    // R5: enable bit appears in status after the command write
    p_ie_a_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr |=> status[2] == $past(cmd_in[4]));

    // R6: buffer flag only rises after a low synchronized strobe
    p_bf_on_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[1]) |-> $past(!stb_a_s));

    // R7: request only rises after a high strobe with enable set
    p_intr_en_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[0]) |-> ($past(stb_a_s) && $past(status[2])));

    // R11: no handshake, no flags
    p_idle_flags_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!hs_a_act) |-> status[1:0] == 2'b00);
endmodule

bind hsport_ctrl hsport_ctrl_chk #(.PW(PW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_wr   (cmd_wr),
    .cmd_in   (cmd_in),
    .wr_a     (wr_a),
    .wr_data  (wr_data),
    .pa_oe    (pa_oe),
    .pa_out   (pa_out),
    .status   (status),
    .stb_a_s  (stb_a_s),
    .hs_a_act (hs_a_act)
);

// File: tb/hsport_ctrl_tb.sv
module hsport_ctrl_tb;
    localparam int PW  = 8;
    localparam int PCW = 6;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           cmd_wr = 1'b0;
    logic [5:0]     cmd_in = '0;
    logic           wr_a = 1'b0, wr_b = 1'b0, wr_c = 1'b0;
    logic [PW-1:0]  wr_data = '0;
    logic           rd_a = 1'b0, rd_b = 1'b0;
    logic [PW-1:0]  pa_in = '0, pb_in = '0;
    logic [PCW-1:0] pc_in = '1;
    logic [PW-1:0]  pa_out, pa_oe, pb_out, pb_oe, pa_rdata, pb_rdata;
    logic [PCW-1:0] pc_out, pc_oe, pc_rdata;
    logic [5:0]     status;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    hsport_ctrl #(.PW(PW), .PCW(PCW)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_in(cmd_in),
        .wr_a(wr_a), .wr_b(wr_b), .wr_c(wr_c), .wr_data(wr_data),
        .rd_a(rd_a), .rd_b(rd_b),
        .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
        .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
        .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe),
        .pa_rdata(pa_rdata), .pb_rdata(pb_rdata), .pc_rdata(pc_rdata),
        .status(status)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic put_cmd(input logic [5:0] v);
        @(negedge clk); cmd_wr = 1'b1; cmd_in = v;
        @(negedge clk); cmd_wr = 1'b0;
    endtask

    task automatic host_wr(input int port, input logic [PW-1:0] d);
        @(negedge clk);
        wr_data = d;
        wr_a = (port == 0); wr_b = (port == 1); wr_c = (port == 2);
        @(negedge clk); wr_a = 1'b0; wr_b = 1'b0; wr_c = 1'b0;
    endtask

    task automatic host_rd_a();
        @(negedge clk); rd_a = 1'b1;
        @(negedge clk); rd_a = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 pa_oe", pa_oe, 0);
        chk("R1 pb_oe", pb_oe, 0);
        chk("R1 pc_oe", pc_oe, 0);
        chk("R1 status", status, 0);
    endtask

    task automatic t_direction();
        put_cmd(6'h03);
        chk("R2 pa_oe out", pa_oe, 8'hFF);
        chk("R2 pb_oe out", pb_oe, 8'hFF);
        host_wr(0, 8'h5A);
        chk("R3 pa_out", pa_out, 8'h5A);
        chk("R3 pa_rdata latch", pa_rdata, 8'h5A);
        host_wr(1, 8'hC3);
        chk("R3 pb_out", pb_out, 8'hC3);
        put_cmd(6'h00);
        pa_in = 8'h81;
        @(negedge clk);
        chk("R2 pa_oe in", pa_oe, 0);
        chk("R2 pa_rdata live", pa_rdata, 8'h81);
    endtask

    task automatic t_pc_modes();
        host_wr(2, 8'h2D);
        put_cmd(6'h0C);
        chk("R4 mode11 oe", pc_oe, 6'b111111);
        chk("R4 mode11 out", pc_out, 6'h2D);
        put_cmd(6'h04);
        chk("R4 mode01 oe", pc_oe, 6'b111110);
        chk("R4 mode01 upper", pc_out[5:3], 3'b101);
        put_cmd(6'h08);
        chk("R4 mode10 oe", pc_oe, 6'b110110);
        put_cmd(6'h00);
        chk("R4 mode00 oe", pc_oe, 6'b000000);
    endtask

    task automatic t_in_handshake();
        put_cmd(6'h14);                     // mode 01, A input, A enable
        chk("R5 ie_a bit2", status, 6'b000100);
        pa_in = 8'h3C;
        @(negedge clk); pc_in[0] = 1'b0;
        repeat (2) @(negedge clk);
        chk("R10 bf not yet", status[1], 1'b0);
        @(negedge clk);
        chk("R10 bf on third edge", status[1], 1'b1);
        chk("R6 bf status", status, 6'b000110);
        chk("R4 bf pin", pc_out[1], 1'b1);
        pa_in = 8'h00;
        @(negedge clk);
        chk("R6 captured data", pa_rdata, 8'h3C);
        @(negedge clk); pc_in[0] = 1'b1;
        repeat (2) @(negedge clk);
        chk("R10 intr not yet", status[0], 1'b0);
        @(negedge clk);
        chk("R7 intr set", status[0], 1'b1);
        chk("R4 intr pin", pc_out[2], 1'b1);
        host_rd_a();
        chk("R8 read clears", status[1:0], 2'b00);
    endtask

    task automatic t_no_enable();
        put_cmd(6'h04);
        @(negedge clk); pc_in[0] = 1'b0;
        repeat (4) @(negedge clk);
        chk("R7 bf without ie", status[1], 1'b1);
        pc_in[0] = 1'b1;
        repeat (5) @(negedge clk);
        chk("R7 no intr without ie", status[0], 1'b0);
        host_rd_a();
    endtask

    task automatic t_out_handshake();
        put_cmd(6'h2A);                     // mode 10, B output, B enable
        chk("R5 ie_b bit5", status, 6'b100000);
        @(negedge clk); pc_in[3] = 1'b0;
        repeat (4) @(negedge clk);
        chk("R9 strobe sets empty", status[4], 1'b1);
        chk("R4 B bf pin", pc_out[4], 1'b1);
        pc_in[3] = 1'b1;
        repeat (4) @(negedge clk);
        chk("R9 rise sets intr", status[4:3], 2'b11);
        @(negedge clk); rd_b = 1'b1;
        @(negedge clk); rd_b = 1'b0;
        chk("R9 read does not clear", status[4:3], 2'b11);
        host_wr(1, 8'h77);
        chk("R9 write clears", status[4:3], 2'b00);
        chk("R9 pb_out", pb_out, 8'h77);
    endtask

    task automatic t_inactive();
        put_cmd(6'h30);                     // mode 00, enables set
        @(negedge clk); pc_in[0] = 1'b0; pc_in[3] = 1'b0;
        repeat (4) @(negedge clk);
        pc_in[0] = 1'b1; pc_in[3] = 1'b1;
        repeat (4) @(negedge clk);
        chk("R11 flags stay clear", status, 6'b100100);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_direction();
        t_pc_modes();
        t_in_handshake();
        t_no_enable();
        t_out_handshake();
        t_inactive();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        #80000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule